// File: doc/BRIEF.md
# Signed-Magnitude Restoring Divider

This block divides a double-width unsigned magnitude by a single-width magnitude, each with its own sign bit, and produces a signed-magnitude quotient and remainder. The work is spread over several clock cycles. A single-cycle `start` pulse captures the operands. The block first runs an overflow test, comparing the upper half of the dividend against the divisor. If that test passes, it runs one iteration per quotient bit. Each iteration does a left shift of the carry/remainder/quotient chain, a trial subtraction, insertion of a quotient bit, and an add-back step whenever the trial subtraction goes negative.

A one-cycle `done` pulse ends every operation, whether it ran to completion or aborted on overflow. The results stay on the outputs until the next accepted `start`. The operand width `N` is a parameter, with a default of 8. A second parameter picks either an explicit ripple-carry chain or an inferred adder for the shared complement-and-add unit.

Top module: `sm_div_top`

## Requirements
- R1: When the upper N bits of the dividend are less than the divisor, `quot_mag` equals floor(dividend / divisor), `rem_mag` equals dividend mod divisor, and `dvf` is 0 when `done` is high.
- R2: `quot_sign` equals the XOR of `dividend_sign` and `divisor_sign`. A sign bit of 1 means negative.
- R3: `rem_sign` equals `dividend_sign`, on both normal and overflow completion.
- R4: When the upper N bits of the dividend are greater than or equal to the divisor, `dvf` is 1 and `done` rises after clock edge 2, counting the edge that accepts `start` as edge 1. In that case `rem_mag` holds the upper half of the dividend and `quot_mag` holds the lower half, both unchanged.
- R5: A divisor magnitude of zero always sets `dvf`, whatever the dividend.
- R6: `done` is high for exactly one cycle per operation. The result outputs then hold their values until the next accepted `start`.
- R7: On normal completion, `done` rises after an edge numbered between 2N+2 and 3N+2 inclusive, counting the accepting edge as edge 1.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. The running operation's results are not disturbed.
- R9: After reset, `done`, `dvf`, both signs and both magnitudes are 0.
- R10: Divisors with their most significant bit set are divided correctly. In that case the bit shifted out of the remainder forces the subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| dividend_sign | input | 1 | Dividend sign (1 = negative) |
| dividend_mag | input | 2N | Dividend magnitude |
| divisor_sign | input | 1 | Divisor sign (1 = negative) |
| divisor_mag | input | N | Divisor magnitude |
| quot_sign | output | 1 | Quotient sign |
| quot_mag | output | N | Quotient magnitude |
| rem_sign | output | 1 | Remainder sign |
| rem_mag | output | N | Remainder magnitude |
| dvf | output | 1 | Divide overflow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
A partial remainder that drifts to or above the divisor, for example after an add-back that is skipped or applied twice, shows up at the ports as a wrong `rem_mag` and a wrong quotient in the very operation it occurs in. It becomes visible at that operation's `done`. A miscounted sequence counter shows up as a `done` that rises outside the 2N+2 to 3N+2 window, and as a quotient shifted by whole bit positions. A faulty overflow decision shows up at the second edge: either `done` and `dvf` appear there when they should not, or they are missing when they should appear.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CHECK   = 3'd1,
      ST_SHIFT   = 3'd2,
      ST_TRIAL   = 3'd3,
      ST_RESTORE = 3'd4,
      ST_FIN     = 3'd5
   } div_state_t;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } addsub_op_t;

endpackage

// File: rtl/smd_addsub.sv
// Shared complement-and-add unit: a + b, or a + ~b + 1, with carry out.
module smd_addsub
   import sm_div_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  addsub_op_t   op,
   output logic [W-1:0] sum,
   output logic         cout
);

   logic [W-1:0] b_eff;
   logic         cin;

   assign b_eff = (op == OP_SUB) ? ~b_in : b_in;
   assign cin   = (op == OP_SUB);

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] carry;
         assign carry[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = a_in[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a_in[i] & b_eff[i]) | (carry[i] & (a_in[i] ^ b_eff[i]));
         end
         assign cout = carry[W];
      end else begin : g_infer
         logic [W:0] full;
         assign full = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, cin};
         assign sum  = full[W-1:0];
         assign cout = full[W];
      end
   endgenerate

endmodule

// File: rtl/smd_ctrl.sv
// Sequencer: state machine plus down-counting step counter.
module smd_ctrl
   import sm_div_pkg::*;
#(
   parameter int N   = 8,
   localparam int SCW = $clog2(N + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       e_bit,
   input  logic       add_cout,
   output div_state_t state,
   output logic [SCW-1:0] sc
);

   localparam logic [SCW-1:0] SC_INIT = SCW'(N);

   div_state_t state_nx;
   logic       last_step;

   assign last_step = (sc == '0);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (start) state_nx = ST_CHECK;
         ST_CHECK:   state_nx = add_cout ? ST_FIN : ST_SHIFT;
         ST_SHIFT:   state_nx = ST_TRIAL;
         ST_TRIAL: begin
            if (!e_bit && !add_cout) state_nx = ST_RESTORE;
            else                     state_nx = last_step ? ST_FIN : ST_SHIFT;
         end
         ST_RESTORE: state_nx = last_step ? ST_FIN : ST_SHIFT;
         ST_FIN:     state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sc    <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && start) sc <= SC_INIT;
         else if (state == ST_SHIFT)    sc <= sc - 1'b1;
      end
   end

endmodule

// File: rtl/smd_regs.sv
// Datapath registers: E, A, Q, B, signs and overflow flag.
module smd_regs
   import sm_div_pkg::*;
#(
   parameter int N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  div_state_t     state,
   input  logic           start,
   input  logic           dd_sign,
   input  logic [2*N-1:0] dd_mag,
   input  logic           dr_sign,
   input  logic [N-1:0]   dr_mag,
   input  logic [N-1:0]   add_sum,
   input  logic           add_cout,
   output addsub_op_t     add_op,
   output logic           e_q,
   output logic [N-1:0]   a_q,
   output logic [N-1:0]   q_q,
   output logic [N-1:0]   b_q,
   output logic           qs_q,
   output logic           rs_q,
   output logic           dvf_q
);

   assign add_op = (state == ST_RESTORE) ? OP_ADD : OP_SUB;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_q   <= 1'b0;
         a_q   <= '0;
         q_q   <= '0;
         b_q   <= '0;
         qs_q  <= 1'b0;
         rs_q  <= 1'b0;
         dvf_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  e_q   <= 1'b0;
                  a_q   <= dd_mag[2*N-1:N];
                  q_q   <= dd_mag[N-1:0];
                  b_q   <= dr_mag;
                  qs_q  <= dd_sign ^ dr_sign;
                  rs_q  <= dd_sign;
                  dvf_q <= 1'b0;
               end
            end
            ST_CHECK: begin
               // A is never overwritten by the test, so it needs no restore.
               if (add_cout) dvf_q <= 1'b1;
            end
            ST_SHIFT: begin
               e_q <= a_q[N-1];
               a_q <= {a_q[N-2:0], q_q[N-1]};
               q_q <= {q_q[N-2:0], 1'b0};
            end
            ST_TRIAL: begin
               a_q <= add_sum;
               e_q <= 1'b0;
               if (e_q || add_cout) q_q[0] <= 1'b1;
            end
            ST_RESTORE: begin
               a_q <= add_sum;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sm_div_top.sv
module sm_div_top
   import sm_div_pkg::*;
#(
   parameter int N      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           dividend_sign,
   input  logic [2*N-1:0] dividend_mag,
   input  logic           divisor_sign,
   input  logic [N-1:0]   divisor_mag,
   output logic           quot_sign,
   output logic [N-1:0]   quot_mag,
   output logic           rem_sign,
   output logic [N-1:0]   rem_mag,
   output logic           dvf,
   output logic           done
);

   localparam int SCW = $clog2(N + 1);

   generate
      if (N < 2) begin : g_bad_width
         $error("sm_div_top: N must be at least 2");
      end
   endgenerate

   div_state_t     state_w;
   logic [SCW-1:0] sc_w;
   addsub_op_t     op_w;
   logic [N-1:0]   sum_w;
   logic           cout_w;
   logic           e_w;
   logic [N-1:0]   a_w;
   logic [N-1:0]   q_w;
   logic [N-1:0]   b_w;

   smd_ctrl #(.N(N)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .e_bit    (e_w),
      .add_cout (cout_w),
      .state    (state_w),
      .sc       (sc_w)
   );

   smd_addsub #(.W(N), .RIPPLE(RIPPLE)) alu_i (
      .a_in (a_w),
      .b_in (b_w),
      .op   (op_w),
      .sum  (sum_w),
      .cout (cout_w)
   );

   smd_regs #(.N(N)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state_w),
      .start    (start),
      .dd_sign  (dividend_sign),
      .dd_mag   (dividend_mag),
      .dr_sign  (divisor_sign),
      .dr_mag   (divisor_mag),
      .add_sum  (sum_w),
      .add_cout (cout_w),
      .add_op   (op_w),
      .e_q      (e_w),
      .a_q      (a_w),
      .q_q      (q_w),
      .b_q      (b_w),
      .qs_q     (quot_sign),
      .rs_q     (rem_sign),
      .dvf_q    (dvf)
   );

   assign quot_mag = q_w;
   assign rem_mag  = a_w;
   assign done     = (state_w == ST_FIN);

endmodule

// File: rtl/sm_div_chk.sv
module sm_div_chk
   import sm_div_pkg::*;
#(
   parameter int N = 8,
   localparam int SCW = $clog2(N + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           done,
   input logic           dvf,
   input div_state_t     state,
   input logic [N-1:0]   a_reg,
   input logic [N-1:0]   b_reg,
   input logic [SCW-1:0] sc
);

   // R6: completion pulse lasts one cycle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: overflow test failing ends the operation on the next edge with the flag set
   p_overflow_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && a_reg >= b_reg) |=> (done && dvf));

   // R5: zero divisor always overflows
   p_zero_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && b_reg == '0) |=> dvf);

   // R1: partial remainder stays below the divisor at each iteration start
   p_partial_below_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (a_reg < b_reg));

   // R1: final remainder below divisor on normal completion
   p_remainder_below_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !dvf) |-> (a_reg < b_reg));

   // R7: step counter never exceeds the quotient width
   p_sc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sc <= SCW'(N));

endmodule

bind sm_div_top sm_div_chk #(.N(N)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .done  (done),
   .dvf   (dvf),
   .state (state_w),
   .a_reg (a_w),
   .b_reg (b_w),
   .sc    (sc_w)
);

// File: tb/sm_div_top_tb_top.sv
`timescale 1ns/1ps
module sm_div_top_tb_top;

   localparam int N = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           dividend_sign = 1'b0;
   logic [2*N-1:0] dividend_mag = '0;
   logic           divisor_sign = 1'b0;
   logic [N-1:0]   divisor_mag = '0;
   logic           quot_sign;
   logic [N-1:0]   quot_mag;
   logic           rem_sign;
   logic [N-1:0]   rem_mag;
   logic           dvf;
   logic           done;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   sm_div_top #(.N(N)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .dividend_sign (dividend_sign),
      .dividend_mag  (dividend_mag),
      .divisor_sign  (divisor_sign),
      .divisor_mag   (divisor_mag),
      .quot_sign     (quot_sign),
      .quot_mag      (quot_mag),
      .rem_sign      (rem_sign),
      .rem_mag       (rem_mag),
      .dvf           (dvf),
      .done          (done)
   );

   // {dividend sign, dividend magnitude, divisor sign, divisor magnitude}
   localparam logic [2*N+N+1:0] VEC [0:11] = '{
      {1'b0, 16'h01C0, 1'b0, 8'd17},
      {1'b1, 16'h1234, 1'b0, 8'h35},
      {1'b0, 16'hFEFF, 1'b1, 8'hFF},
      {1'b1, 16'h0000, 1'b1, 8'h05},
      {1'b0, 16'h00AB, 1'b0, 8'h01},
      {1'b1, 16'hC000, 1'b0, 8'hC1},
      {1'b0, 16'h7F80, 1'b1, 8'h80},
      {1'b0, 16'h4000, 1'b0, 8'h40},
      {1'b1, 16'hFFFF, 1'b0, 8'hFF},
      {1'b0, 16'h0312, 1'b1, 8'h00},
      {1'b1, 16'h0001, 1'b1, 8'hFE},
      {1'b0, 16'h9999, 1'b0, 8'hAB}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   // Drives one operation; returns the count of negedges until done is seen.
   task automatic run_op(input logic s_dd, input logic [2*N-1:0] dd,
                         input logic s_dr, input logic [N-1:0] dr,
                         output int lat);
      @(negedge clk);
      dividend_sign = s_dd; dividend_mag = dd;
      divisor_sign  = s_dr; divisor_mag  = dr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
         end
      end
   end

   initial begin : main
      int lat;
      logic [31:0] eq, er;
      logic        eovf;
      logic [N-1:0] hold_q, hold_r;

      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 done", done, 0);
      chk("R9 dvf", dvf, 0);
      chk("R9 quot", {quot_sign, quot_mag}, 0);
      chk("R9 rem", {rem_sign, rem_mag}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < 12; i++) begin
         logic           s_dd, s_dr;
         logic [2*N-1:0] dd;
         logic [N-1:0]   dr;
         {s_dd, dd, s_dr, dr} = VEC[i];
         eovf = (dd[2*N-1:N] >= dr);
         if (!eovf) begin
            eq = 32'(dd / {{N{1'b0}}, dr});
            er = 32'(dd % {{N{1'b0}}, dr});
         end else begin
            eq = 32'(dd[N-1:0]);
            er = 32'(dd[2*N-1:N]);
         end
         run_op(s_dd, dd, s_dr, dr, lat);
         chk(eovf ? "R4 dvf" : "R1 dvf", dvf, eovf);
         chk(eovf ? "R4 quot" : "R1 quot", quot_mag, eq);
         chk(eovf ? "R4 rem" : "R1 rem", rem_mag, er);
         chk("R2 qsign", quot_sign, s_dd ^ s_dr);
         chk("R3 rsign", rem_sign, s_dd);
         if (eovf) chk("R4 latency", lat, 2);
         else chk("R7 latency", (lat >= 2*N+2 && lat <= 3*N+2), 1);
         if (dr == '0) chk("R5 zero divisor", dvf, 1);
         if (dr[N-1] && !eovf) chk("R10 msb divisor", {quot_mag, rem_mag}, {eq[N-1:0], er[N-1:0]});
         hold_q = quot_mag; hold_r = rem_mag;
         @(negedge clk);
         chk("R6 single pulse", done, 0);
         repeat (3) @(negedge clk);
         chk("R6 hold", {quot_mag, rem_mag}, {hold_q, hold_r});
      end

      // R8: start while busy is ignored
      @(negedge clk);
      dividend_sign = 1'b0; dividend_mag = 16'h1000; divisor_sign = 1'b0; divisor_mag = 8'h21;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      dividend_sign = 1'b1; dividend_mag = 16'h0050; divisor_sign = 1'b1; divisor_mag = 8'h03;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk("R8 quot", {quot_sign, quot_mag}, {1'b0, 8'(16'h1000 / 16'h21)});
      chk("R8 rem", {rem_sign, rem_mag}, {1'b0, 8'(16'h1000 % 16'h21)});
      @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R8 no second done", done, 0);

      finish_run();
   end

endmodule